// File: doc/BRIEF.md
# I2C Memory Slave with Write-Protected Range

This block is an I2C target that gives a bus master byte access to a small register-file memory inside the chip. It oversamples the SCL and SDA lines in the system clock domain, recognises START, Repeated START and STOP conditions, and moves 8-bit bytes most significant bit first, each followed by an acknowledge clock. A write carries the device address byte, two pointer bytes and any number of data bytes. A read starts from the current pointer value. That value is either left over from earlier traffic or set by a pointer-only write followed by a Repeated START.

A range of the array, `wp_lo` to `wp_hi` inclusive, is write-protected. When the master sends a data byte aimed at a protected location, the slave does not acknowledge it and leaves the array unchanged. It then ignores the bus until the next START or STOP. During a read, the slave stops driving SDA as soon as the master leaves the acknowledge bit high.

The block drives SDA only through an open-drain enable. When `sda_oe` is 1, the pad pulls SDA low. Clock stretching, arbitration and 10-bit addressing are not present.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, the pointer is 0 and every memory byte reads 0.
- R2: After a START, the slave compares the first byte's upper 7 bits with `DEV_ADDR`. On a match it pulls SDA low on the ninth clock. On a mismatch it leaves SDA high and ignores all later bytes until the next START.
- R3: In a write, bit 0 of the device byte is 0 and the next two bytes set the pointer; the second byte supplies the low 8 bits and the first byte supplies any bits above them. Every following data byte is acknowledged and stored at the pointer, with its first transmitted bit as bit 7.
- R4: After each stored or transmitted byte, the pointer advances by one and wraps from 2^ADDR_W-1 to 0.
- R5: A data byte whose target address satisfies `wp_lo` <= address <= `wp_hi` gets no acknowledge and does not change the memory. Every byte after it is also left unacknowledged until a START or STOP.
- R6: A device byte with bit 0 equal to 1, whether it follows a START or a Repeated START, begins a read at the current pointer. The slave sends bit 7 first, and consecutive bytes come from consecutive addresses.
- R7: When the master leaves SDA high on the acknowledge clock of a read byte, the slave releases SDA. It keeps SDA released through any further clocks until a START or STOP.
- R8: After a STOP, the slave releases SDA and acknowledges nothing until a new START.
- R9: The slave changes `sda_oe` only while SCL is low, so every bit it drives holds steady for the whole high phase of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 leaves the line released |
| wp_lo | input | ADDR_W | Lowest write-protected address |
| wp_hi | input | ADDR_W | Highest write-protected address (range is empty when below `wp_lo`) |

## Verification
The address decode is tried with a foreign device byte, then with data bytes that follow it. An acknowledge there would show that a mismatch does not park the slave. Writes are made as a short run in mid-array, as a run that crosses the top address, and as a run that steps from an open address into the protected window. Reading each run back separates a correct store from a pointer that fails to wrap or a protection compare that is off by one at either edge. Reads are tried as a random read through a Repeated START, as a read that continues from the left-over pointer, and as a read ended by a master NACK followed by idle clocks. Bytes clocked after a STOP without a START show whether the slave truly returns to idle.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

   localparam int BYTE_W   = 8;
   localparam int FRAME_W  = 4;   // holds bit counts 0..9
   localparam int ACK_SLOT = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_PTR_HI,
      ST_PTR_LO,
      ST_WRITE,
      ST_READ
   } i2cm_state_e;

endpackage

// File: rtl/i2cm_line_sync.sv
`timescale 1ns/1ps
module i2cm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   // idle bus is high, so the pipes reset to ones
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_wp_guard.sv
`timescale 1ns/1ps
module i2cm_wp_guard #(
   parameter int ADDR_W    = 6,
   parameter bit WP_ENABLE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              hit
);

   if (WP_ENABLE) begin : g_guard
      assign hit = (addr >= lo) && (addr <= hi);
   end else begin : g_open
      logic unused_wp;
      assign unused_wp = ^{addr, lo, hi};
      assign hit       = 1'b0;
   end

endmodule

// File: rtl/i2cm_store.sv
`timescale 1ns/1ps
module i2cm_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h52,
   parameter int         ADDR_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                sda_s,
   input  logic                start_det,
   input  logic                stop_det,
   input  logic                wp_hit,
   input  logic [BYTE_W-1:0]   rd_data,
   output logic                wr_en,
   output logic [BYTE_W-1:0]   wr_data,
   output logic [ADDR_W-1:0]   ptr,
   output logic                sda_oe
);

   i2cm_state_e         state;
   i2cm_state_e         pend;
   i2cm_state_e         nxt_st;
   logic [FRAME_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   tx;
   logic [BYTE_W-1:0]   hi_q;
   logic                mnack;
   logic                ack_ok;
   logic                byte_end;
   logic                frame_end;
   logic [ADDR_W-1:0]   new_ptr;
   logic                unused_hi;

   assign unused_hi = ^hi_q;

   // pointer assembly depends on how many bits the high byte contributes
   if (ADDR_W > BYTE_W) begin : g_ptr_wide
      assign new_ptr = {hi_q[ADDR_W-BYTE_W-1:0], shreg};
   end else begin : g_ptr_narrow
      assign new_ptr = shreg[ADDR_W-1:0];
   end

   assign byte_end  = scl_fall && (bit_cnt == FRAME_W'(BYTE_W));
   assign frame_end = scl_fall && (bit_cnt == FRAME_W'(ACK_SLOT));

   // acknowledge decision and follow-on state at the end of a received byte
   always_comb begin
      ack_ok = 1'b0;
      nxt_st = ST_IDLE;
      unique case (state)
         ST_DEV: begin
            ack_ok = (shreg[BYTE_W-1:1] == DEV_ADDR);
            if (ack_ok) nxt_st = shreg[0] ? ST_READ : ST_PTR_HI;
         end
         ST_PTR_HI: begin
            ack_ok = 1'b1;
            nxt_st = ST_PTR_LO;
         end
         ST_PTR_LO: begin
            ack_ok = 1'b1;
            nxt_st = ST_WRITE;
         end
         ST_WRITE: begin
            ack_ok = !wp_hit;
            nxt_st = wp_hit ? ST_IDLE : ST_WRITE;
         end
         default: begin
            ack_ok = 1'b0;
            nxt_st = ST_IDLE;
         end
      endcase
   end

   assign wr_en   = (state == ST_WRITE) && byte_end && !wp_hit && !start_det && !stop_det;
   assign wr_data = shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pend    <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         tx      <= '0;
         hi_q    <= '0;
         mnack   <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
      end else if (start_det) begin
         state   <= ST_DEV;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (bit_cnt < FRAME_W'(BYTE_W)) shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (state == ST_READ && bit_cnt == FRAME_W'(BYTE_W)) mnack <= sda_s;
            if (bit_cnt < FRAME_W'(ACK_SLOT)) bit_cnt <= bit_cnt + 1'b1;
         end else if (state == ST_READ && scl_fall) begin
            if (bit_cnt >= 1 && bit_cnt < FRAME_W'(BYTE_W)) begin
               tx     <= {tx[BYTE_W-2:0], 1'b0};
               sda_oe <= ~tx[BYTE_W-2];
            end else if (byte_end) begin
               sda_oe <= 1'b0;
            end else if (frame_end) begin
               bit_cnt <= '0;
               if (mnack) begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
               end else begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[BYTE_W-1];
                  ptr    <= ptr + 1'b1;
               end
            end
         end else if (byte_end) begin
            sda_oe <= ack_ok;
            pend   <= nxt_st;
            if (state == ST_PTR_HI) hi_q <= shreg;
            if (state == ST_PTR_LO) ptr  <= new_ptr;
            if (wr_en)              ptr  <= ptr + 1'b1;
         end else if (frame_end) begin
            bit_cnt <= '0;
            state   <= pend;
            if (pend == ST_READ) begin
               tx     <= rd_data;
               sda_oe <= ~rd_data[BYTE_W-1];
               ptr    <= ptr + 1'b1;
            end else begin
               sda_oe <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
   import i2cm_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h52,
   parameter int         ADDR_W      = 6,
   parameter int         SYNC_STAGES = 2,
   parameter bit         WP_ENABLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] wp_lo,
   input  logic [ADDR_W-1:0] wp_hi
);

   if (ADDR_W < 1 || ADDR_W > 2 * BYTE_W) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wp_hit;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_data;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] wr_addr;
   logic              unused_scl;

   assign unused_scl = scl_s;
   assign wr_addr    = ptr;

   i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cm_wp_guard #(.ADDR_W(ADDR_W), .WP_ENABLE(WP_ENABLE)) u_guard (
      .addr (ptr),
      .lo   (wp_lo),
      .hi   (wp_hi),
      .hit  (wp_hit)
   );

   i2cm_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (ptr),
      .rdata (rd_data)
   );

   i2cm_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .wp_hit    (wp_hit),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .ptr       (ptr),
      .sda_oe    (sda_oe)
   );

endmodule

// File: rtl/i2cm_checker.sv
`timescale 1ns/1ps
module i2cm_checker #(
   parameter int ADDR_W    = 6,
   parameter bit WP_ENABLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              start_det,
   input logic              stop_det,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] ptr,
   input logic [ADDR_W-1:0] wp_lo,
   input logic [ADDR_W-1:0] wp_hi
);

   // R9: the drive enable moves only after SCL has gone low
   assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i));

   // R2: a START always leaves the line released
   assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_det) |-> !sda_oe);

   // R8: a STOP always leaves the line released
   assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_oe);

   // R5: no store reaches a protected location
   assert_no_prot_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !(WP_ENABLE && wr_addr >= wp_lo && wr_addr <= wp_hi));

   // R4: each store advances the pointer by one, modulo the array size
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == ADDR_W'($past(wr_addr) + 1'b1)));

endmodule

bind i2c_mem_slave i2cm_checker #(.ADDR_W(ADDR_W), .WP_ENABLE(WP_ENABLE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe),
   .start_det (start_det),
   .stop_det  (stop_det),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .ptr       (ptr),
   .wp_lo     (wp_lo),
   .wp_hi     (wp_hi)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;

   localparam logic [6:0] DEV = 7'h52;
   localparam int         AW  = 6;
   localparam int         Q   = 50;   // quarter SCL period in ns

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic [AW-1:0] wp_lo = 6'h30;
   logic [AW-1:0] wp_hi = 6'h37;
   wire           sda_oe;
   wire           sda_bus = sda_m & ~sda_oe;

   int            checks = 0;
   int            errors = 0;
   logic [7:0]    ref_mem [1 << AW];

   always #2.5 clk = ~clk;

   i2c_mem_slave #(.DEV_ADDR(DEV), .ADDR_W(AW)) i_i2c_mem_slave (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_m),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe),
      .wp_lo  (wp_lo),
      .wp_hi  (wp_hi)
   );

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; #Q;
      scl_m = 1'b1; #(2*Q);
      scl_m = 1'b0; #Q;
   endtask

   task automatic do_start;
      if (!scl_m) begin
         sda_m = 1'b1; #Q;
         scl_m = 1'b1; #Q;
      end
      sda_m = 1'b0; #Q;
      scl_m = 1'b0; #Q;
   endtask

   task automatic do_stop;
      sda_m = 1'b0; #Q;
      scl_m = 1'b1; #Q;
      sda_m = 1'b1; #Q;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; #Q;
      scl_m = 1'b1; #Q;
      acked = !sda_bus; #Q;
      scl_m = 1'b0; #Q;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
      steady = 1'b1;
      sda_m  = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl_m = 1'b1;
         #Q; b[i] = sda_bus;
         #(Q/2); if (sda_bus !== b[i]) steady = 1'b0;
         #(Q/2); scl_m = 1'b0;
      end
      #Q; sda_m = !give_ack;
      #Q; scl_m = 1'b1;
      #(2*Q); scl_m = 1'b0;
      #Q; sda_m = 1'b1;
   endtask

   task automatic send_expect(input logic [7:0] b, input bit exp_ack, input string req);
      bit a;
      send_byte(b, a);
      chk(a == exp_ack, req, 8'(a), 8'(exp_ack));
   endtask

   // pointer-only write, then Repeated START into a read
   task automatic point_and_read(input logic [AW-1:0] addr, input string req);
      do_start;
      send_expect({DEV, 1'b0}, 1'b1, req);
      send_expect(8'h00, 1'b1, req);
      send_expect(8'(addr), 1'b1, req);
      do_start;
      send_expect({DEV, 1'b1}, 1'b1, req);
   endtask

   task automatic read_run(input logic [AW-1:0] addr, input int n, input string req);
      logic [7:0] b;
      bit         s;
      point_and_read(addr, req);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, b, s);
         chk(b == ref_mem[AW'(addr + AW'(k))], req, b, ref_mem[AW'(addr + AW'(k))]);
         chk(s, "R9 steady while SCL high", 8'(s), 8'd1);
      end
      do_stop;
   endtask

   task automatic write_run(input logic [AW-1:0] addr, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2, input string req);
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      do_start;
      send_expect({DEV, 1'b0}, 1'b1, req);
      send_expect(8'h00, 1'b1, req);
      send_expect(8'(addr), 1'b1, req);
      for (int k = 0; k < 3; k++) begin
         send_expect(d[k], 1'b1, req);
         ref_mem[AW'(addr + AW'(k))] = d[k];
      end
      do_stop;
   endtask

   task automatic t_reset;
      chk(sda_oe == 1'b0, "R1 released after reset", 8'(sda_oe), 8'd0);
      read_run(6'h00, 2, "R1 memory cleared");
   endtask

   task automatic t_bad_addr;
      do_start;
      send_expect({7'h11, 1'b0}, 1'b0, "R2 foreign address NACK");
      send_expect(8'h00, 1'b0, "R2 ignored after mismatch");
      send_expect(8'h5A, 1'b0, "R2 ignored after mismatch");
      do_stop;
   endtask

   task automatic t_write_read;
      logic [7:0] b;
      bit         s;
      write_run(6'h05, 8'hA5, 8'h3C, 8'h81, "R3 write acknowledged");
      read_run(6'h05, 3, "R6 random read");
      // plain START read continues from the pointer left at 0x08
      do_start;
      send_expect({DEV, 1'b1}, 1'b1, "R6 read from current pointer");
      recv_byte(1'b0, b, s);
      chk(b == ref_mem[8], "R6 read from current pointer", b, ref_mem[8]);
      do_stop;
   endtask

   task automatic t_wrap;
      write_run(6'h3E, 8'h11, 8'h22, 8'h33, "R4 write across top");
      read_run(6'h3E, 3, "R4 pointer wrap");
   endtask

   task automatic t_protect;
      do_start;
      send_expect({DEV, 1'b0}, 1'b1, "R5 setup");
      send_expect(8'h00, 1'b1, "R5 setup");
      send_expect(8'h2F, 1'b1, "R5 setup");
      send_expect(8'h77, 1'b1, "R5 open address below window");
      ref_mem[6'h2F] = 8'h77;
      send_expect(8'h99, 1'b0, "R5 protected NACK at window start");
      send_expect(8'h44, 1'b0, "R5 aborted transfer ignored");
      do_stop;
      do_start;
      send_expect({DEV, 1'b0}, 1'b1, "R5 setup");
      send_expect(8'h00, 1'b1, "R5 setup");
      send_expect(8'h37, 1'b1, "R5 setup");
      send_expect(8'hEE, 1'b0, "R5 protected NACK at window end");
      do_stop;
      do_start;
      send_expect({DEV, 1'b0}, 1'b1, "R5 setup");
      send_expect(8'h00, 1'b1, "R5 setup");
      send_expect(8'h38, 1'b1, "R5 setup");
      send_expect(8'h5D, 1'b1, "R5 open address above window");
      ref_mem[6'h38] = 8'h5D;
      do_stop;
      read_run(6'h2F, 2, "R5 protected byte unchanged");
      read_run(6'h37, 2, "R5 window edge contents");
   endtask

   task automatic t_master_nack;
      logic [7:0] b;
      bit         s;
      point_and_read(6'h05, "R7 setup");
      recv_byte(1'b0, b, s);
      chk(b == ref_mem[5], "R7 byte before NACK", b, ref_mem[5]);
      #Q;
      chk(sda_oe == 1'b0, "R7 released after NACK", 8'(sda_oe), 8'd0);
      for (int k = 0; k < 9; k++) begin
         #Q; scl_m = 1'b1;
         #Q; chk(sda_bus == 1'b1, "R7 line stays released", 8'(sda_bus), 8'd1);
         #Q; scl_m = 1'b0; #Q;
      end
      do_stop;
   endtask

   task automatic t_stop_idle;
      scl_m = 1'b0; #Q;
      send_expect({DEV, 1'b0}, 1'b0, "R8 no START after STOP");
      send_expect(8'h00, 1'b0, "R8 no START after STOP");
      chk(sda_oe == 1'b0, "R8 line released", 8'(sda_oe), 8'd0);
      sda_m = 1'b1; #Q;
      scl_m = 1'b1; #Q;
      read_run(6'h05, 1, "R8 normal after fresh START");
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #600000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run;
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'h00;
      #101;
      rst_n = 1'b1;
      #200;
      t_reset;
      t_bad_addr;
      t_write_read;
      t_wrap;
      t_protect;
      t_master_nack;
      t_stop_idle;
      #500;
      finish_run;
   end

endmodule